// File: doc/BRIEF.md
# Bias-Corrected Pixel Threshold Detector

This block screens a stream of 12-bit pixel samples arriving from four video chains. Each sample comes with its chain number and its column and row in the frame. The block looks up a stored 12-bit bias value for that pixel position and adds the threshold register that belongs to the pixel's chain. It then writes a single hit bit for the pixel into a bitmap. The bit is one only when the sample is strictly larger than the sum. Software later scans the bitmap in 32-bit words to find the pixels that are worth examining.

The same memories are open to software through a simple request port. Through that port software loads and reads back the four thresholds, loads and reads back per-pixel biases, and reads, writes or clears bitmap words. Every stored bias carries an even parity bit. A bias read returns a 16-bit value whose top bit reports a parity mismatch on that entry. Each software access takes the memories for one cycle and holds the pixel pipeline for that cycle, which is signalled through a ready output. The array size is a parameter; by default it is 64 by 64.

Top module: `pixthr_detector`

## Requirements
- R1: After reset, all four thresholds read as zero, every bitmap word reads as zero, and `pixReady` is high while no software request is present.
- R2: There are four 12-bit threshold registers, selected by `swSel`=0 and written or read at `swAddr[1:0]` (the chain number). A read returns the value in bits 11:0 with bits 31:12 zero. Each pixel is compared using the threshold of its own `pixChan`.
- R3: A pixel's bitmap bit becomes 1 when `pixData` is strictly greater than its stored bias plus its chain threshold. It becomes 0 when `pixData` is equal to or below that sum.
- R4: The bias-plus-threshold sum is formed to 13 bits, so bias 0xFFF plus threshold 0xFFF never wraps. A pixel of 0xFFF against that sum gives 0.
- R5: The pixel index is `pixY*COLS + pixX`. Its bit lives in bitmap word index/32 (selected by `swSel`=2, `swAddr` = word index) at bit position index mod 32. A stream update changes only that bit of the word.
- R6: Biases are selected by `swSel`=1 with `swAddr` equal to the pixel index. A write stores `swWdata[11:0]` together with even parity generated over those 12 bits. A read returns the bias in bits 11:0, zeros in bits 14:12 and 31:16, and the parity-error flag in bit 15.
- R7: A bias write with `swWdata[16]`=1 stores the inverted parity bit, so later reads of that entry show bit 15 set. A later write with `swWdata[16]`=0 clears the flag.
- R8: While `swReq` is high, `pixReady` is low in the same cycle and no pixel is accepted. A pixel that was already accepted keeps the bias and threshold captured when it was accepted, even if software rewrites them during the stall.
- R9: With no software request, one pixel is accepted on every clock edge. Its bitmap bit is updated on the next edge.
- R10: A software bitmap write (`swSel`=2, `swWrite`=1) replaces the whole 32-bit word. This is the way to clear the bitmap between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | A pixel sample is offered |
| pixReady | output | 1 | The pixel is taken on this edge when valid |
| pixChan | input | 2 | Video chain of the sample |
| pixX | input | 6 | Pixel column |
| pixY | input | 6 | Pixel row |
| pixData | input | 12 | Pixel pulse height |
| swReq | input | 1 | Software access this cycle |
| swWrite | input | 1 | 1 = write, 0 = read |
| swSel | input | 2 | 0 threshold, 1 bias, 2 bitmap word |
| swAddr | input | 12 | Chain number, pixel index or word index |
| swWdata | input | 32 | Write data; bit 16 inverts the stored bias parity |
| swRdata | output | 32 | Read data, valid in the cycle of the read request |

## Verification
On every cycle the embedded properties check several things. A stalled pipeline stage keeps its captured sum and index. Every stream update leaves the addressed bitmap bit equal to the strict-greater comparison of the captured values. A normal bias write always stores even parity. Software strobes never coincide with a pipeline advance. What only the bench scenarios can show is visible at the ports: the choice between the four thresholds, the 13-bit sum at the top of the range, the bit position inside a read word, the placement of the injected parity flag, the refusal of a pixel offered during a stall, and back-to-back throughput.

// File: rtl/pixthr_pkg.sv
package pixthr_pkg;

  typedef enum logic [1:0] {
    SEL_THR  = 2'd0,
    SEL_BIAS = 2'd1,
    SEL_MAP  = 2'd2,
    SEL_NONE = 2'd3
  } swSel_e;

  typedef struct packed {
    logic   advance;
    logic   thrWr;
    logic   biasWr;
    logic   mapWr;
    swSel_e rdSel;
  } ctrlStrobe_t;

  localparam int MAP_WORD_W = 32;
  localparam int BIAS_RD_W  = 16;
  localparam int INJ_BIT    = 16;

endpackage

// File: rtl/pixthr_ctrl.sv
module pixthr_ctrl
  import pixthr_pkg::*;
(
  input  logic        swReq,
  input  logic        swWrite,
  input  logic [1:0]  swSel,
  output ctrlStrobe_t st,
  output logic        pixReady
);

  swSel_e selIn;
  logic   wrReq;

  always_comb begin
    selIn     = swSel_e'(swSel);
    wrReq     = swReq && swWrite;
    st.advance = !swReq;
    st.thrWr   = wrReq && (selIn == SEL_THR);
    st.biasWr  = wrReq && (selIn == SEL_BIAS);
    st.mapWr   = wrReq && (selIn == SEL_MAP);
    st.rdSel   = swReq ? selIn : SEL_NONE;
    pixReady   = st.advance;
  end

endmodule

// File: rtl/pixthr_datapath.sv
module pixthr_datapath
  import pixthr_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int ROWS  = 64,
  parameter int PIX_W = 12,
  parameter int CHANS = 4,
  localparam int X_W    = $clog2(COLS),
  localparam int Y_W    = $clog2(ROWS),
  localparam int CHAN_W = $clog2(CHANS),
  localparam int ADDR_W = X_W + Y_W
)(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       st,
  input  logic              pixValid,
  input  logic [CHAN_W-1:0] pixChan,
  input  logic [X_W-1:0]    pixX,
  input  logic [Y_W-1:0]    pixY,
  input  logic [PIX_W-1:0]  pixData,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic [31:0]       swWdata,
  output logic [31:0]       swRdata
);

  localparam int NPIX    = COLS * ROWS;
  localparam int NWORDS  = NPIX / MAP_WORD_W;
  localparam int BIT_W   = $clog2(MAP_WORD_W);
  localparam int WORD_W  = ADDR_W - BIT_W;
  localparam int PAD_W   = BIAS_RD_W - 1 - PIX_W;

  logic [PIX_W-1:0]      thrReg  [CHANS];
  logic [PIX_W:0]        biasMem [NPIX];    // {parity, bias}
  logic [MAP_WORD_W-1:0] mapMem  [NWORDS];

  // pipeline stage 1
  logic              s1Valid;
  logic [PIX_W-1:0]  s1Pix;
  logic [PIX_W:0]    s1Sum;
  logic [ADDR_W-1:0] s1Idx;

  logic [ADDR_W-1:0] pixIdx;
  logic [PIX_W:0]    sumNext;
  logic              hit;
  logic              streamWe;
  logic [WORD_W-1:0] s1Word;
  logic [BIT_W-1:0]  s1Bit;

  always_comb begin
    pixIdx   = {pixY, pixX};
    sumNext  = {1'b0, biasMem[pixIdx][PIX_W-1:0]} + {1'b0, thrReg[pixChan]};
    hit      = {1'b0, s1Pix} > s1Sum;
    streamWe = st.advance && s1Valid;
    s1Word   = s1Idx[ADDR_W-1:BIT_W];
    s1Bit    = s1Idx[BIT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
    end else if (st.advance) begin
      s1Valid <= pixValid;
      if (pixValid) begin
        s1Pix <= pixData;
        s1Sum <= sumNext;
        s1Idx <= pixIdx;
      end
    end
  end

  // threshold registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CHANS; i++) thrReg[i] <= '0;
    end else if (st.thrWr) begin
      thrReg[swAddr[CHAN_W-1:0]] <= swWdata[PIX_W-1:0];
    end
  end

  // bias memory with even parity, optional parity inversion for fault injection
  always_ff @(posedge clk) begin
    if (st.biasWr)
      biasMem[swAddr] <= {(^swWdata[PIX_W-1:0]) ^ swWdata[INJ_BIT], swWdata[PIX_W-1:0]};
  end

  // threshold bitmap
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NWORDS; w++) mapMem[w] <= '0;
    end else begin
      if (streamWe) mapMem[s1Word][s1Bit] <= hit;
      if (st.mapWr) mapMem[swAddr[WORD_W-1:0]] <= swWdata;
    end
  end

  // software read path
  logic [PIX_W:0]       biasEntry;
  logic                 biasErr;
  logic [BIAS_RD_W-1:0] biasRd;

  always_comb begin
    biasEntry = biasMem[swAddr];
    biasErr   = ^biasEntry;
    biasRd    = {biasErr, {PAD_W{1'b0}}, biasEntry[PIX_W-1:0]};
    case (st.rdSel)
      SEL_THR:  swRdata = 32'(thrReg[swAddr[CHAN_W-1:0]]);
      SEL_BIAS: swRdata = 32'(biasRd);
      SEL_MAP:  swRdata = mapMem[swAddr[WORD_W-1:0]];
      default:  swRdata = '0;
    endcase
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (s1Valid && !st.advance) |=> (s1Valid && $stable(s1Sum) && $stable(s1Idx))); // R8

  AST_BIT_SET: assert property (@(posedge clk) disable iff (rst)
    (streamWe && hit) |=> mapMem[$past(s1Word)][$past(s1Bit)]); // R3

  AST_BIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (streamWe && !hit) |=> !mapMem[$past(s1Word)][$past(s1Bit)]); // R3

  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
    (st.biasWr && !swWdata[INJ_BIT]) |=> !(^biasMem[$past(swAddr)])); // R6

  AST_SW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.thrWr, st.biasWr, st.mapWr})
    && !(st.advance && (st.thrWr || st.biasWr || st.mapWr))); // R8

endmodule

// File: rtl/pixthr_detector.sv
module pixthr_detector
  import pixthr_pkg::*;
#(
  parameter int COLS  = 64,
  parameter int ROWS  = 64,
  parameter int PIX_W = 12,
  parameter int CHANS = 4,
  localparam int X_W    = $clog2(COLS),
  localparam int Y_W    = $clog2(ROWS),
  localparam int CHAN_W = $clog2(CHANS),
  localparam int ADDR_W = X_W + Y_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              pixValid,
  output logic              pixReady,
  input  logic [CHAN_W-1:0] pixChan,
  input  logic [X_W-1:0]    pixX,
  input  logic [Y_W-1:0]    pixY,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              swReq,
  input  logic              swWrite,
  input  logic [1:0]        swSel,
  input  logic [ADDR_W-1:0] swAddr,
  input  logic [31:0]       swWdata,
  output logic [31:0]       swRdata
);

  ctrlStrobe_t st;

  pixthr_ctrl u_ctrl (
    .swReq    (swReq),
    .swWrite  (swWrite),
    .swSel    (swSel),
    .st       (st),
    .pixReady (pixReady)
  );

  pixthr_datapath #(
    .COLS  (COLS),
    .ROWS  (ROWS),
    .PIX_W (PIX_W),
    .CHANS (CHANS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .pixValid (pixValid),
    .pixChan  (pixChan),
    .pixX     (pixX),
    .pixY     (pixY),
    .pixData  (pixData),
    .swAddr   (swAddr),
    .swWdata  (swWdata),
    .swRdata  (swRdata)
  );

endmodule

// File: tb/pixthr_detector_test.sv
module pixthr_detector_test;

  localparam int COLS = 64;
  localparam int ROWS = 64;
  localparam int NWORDS = COLS * ROWS / 32;

  logic        clk = 1'b0;
  logic        rst;
  logic        pixValid;
  logic        pixReady;
  logic [1:0]  pixChan;
  logic [5:0]  pixX, pixY;
  logic [11:0] pixData;
  logic        swReq, swWrite;
  logic [1:0]  swSel;
  logic [11:0] swAddr;
  logic [31:0] swWdata;
  logic [31:0] swRdata;

  pixthr_detector uut (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixReady(pixReady),
    .pixChan(pixChan), .pixX(pixX), .pixY(pixY), .pixData(pixData),
    .swReq(swReq), .swWrite(swWrite), .swSel(swSel), .swAddr(swAddr),
    .swWdata(swWdata), .swRdata(swRdata)
  );

  always #10 clk = ~clk;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // stimulus table: chain, x, y, bias, threshold, pixel, expected bit
  localparam int V_N = 8;
  localparam int vCh  [V_N] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int vX   [V_N] = '{1, 2, 3, 4, 63, 0, 10, 31};
  localparam int vY   [V_N] = '{0, 0, 1, 1, 63, 63, 20, 7};
  localparam int vB   [V_N] = '{100, 100, 0, 0, 4095, 4000, 0, 1};
  localparam int vT   [V_N] = '{50, 50, 0, 0, 4095, 0, 4095, 2048};
  localparam int vP   [V_N] = '{151, 150, 1, 0, 4095, 4001, 4095, 2050};
  localparam int vE   [V_N] = '{1, 0, 1, 0, 0, 1, 0, 1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic swWr(input logic [1:0] sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    swReq = 1; swWrite = 1; swSel = sel; swAddr = 12'(addr); swWdata = data;
    @(negedge clk);
    swReq = 0; swWrite = 0;
  endtask

  task automatic swRd(input logic [1:0] sel, input int addr, output logic [31:0] data);
    @(negedge clk);
    swReq = 1; swWrite = 0; swSel = sel; swAddr = 12'(addr);
    #1 data = swRdata;
    @(negedge clk);
    swReq = 0;
  endtask

  task automatic sendPix(input int ch, input int x, input int y, input int p);
    @(negedge clk);
    pixValid = 1; pixChan = 2'(ch); pixX = 6'(x); pixY = 6'(y); pixData = 12'(p);
    @(negedge clk);
    pixValid = 0;
  endtask

  task automatic getBit(input int x, input int y, output logic b);
    logic [31:0] w;
    int idx;
    idx = y * COLS + x;
    swRd(2'd2, idx / 32, w);
    b = w[idx % 32];
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] r;
    logic b;
    rst = 1; pixValid = 0; pixChan = 0; pixX = 0; pixY = 0; pixData = 0;
    swReq = 0; swWrite = 0; swSel = 0; swAddr = 0; swWdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    #1 check("R1 ready", 32'(pixReady), 32'd1);
    for (int c = 0; c < 4; c++) begin
      swRd(2'd0, c, r);
      check("R1 threshold", r, 32'd0);
    end
    swRd(2'd2, 0, r);           check("R1 map first", r, 32'd0);
    swRd(2'd2, NWORDS - 1, r);  check("R1 map last", r, 32'd0);

    // R2 threshold readback width
    swWr(2'd0, 2, 32'hFFFF_FFFF);
    swRd(2'd0, 2, r);
    check("R2 readback", r, 32'h0000_0FFF);

    // table walk: R3 strict compare, R4 no wrap, R5 indexing
    for (int i = 0; i < V_N; i++) begin
      swWr(2'd0, vCh[i], 32'(vT[i]));
      swWr(2'd1, vY[i] * COLS + vX[i], 32'(vB[i]));
      sendPix(vCh[i], vX[i], vY[i], vP[i]);
      getBit(vX[i], vY[i], b);
      check($sformatf("R3/R4 vector %0d", i), 32'(b), 32'(vE[i]));
    end

    // R2 chain selection with distinct thresholds
    swWr(2'd0, 0, 32'd10);
    swWr(2'd0, 1, 32'd200);
    swWr(2'd1, 2 * COLS + 5, 32'd0);
    swWr(2'd1, 2 * COLS + 6, 32'd0);
    sendPix(0, 5, 2, 100);
    sendPix(1, 6, 2, 100);
    getBit(5, 2, b); check("R2 chain0", 32'(b), 32'd1);
    getBit(6, 2, b); check("R2 chain1", 32'(b), 32'd0);

    // R6 bias read format, R7 parity injection
    swWr(2'd1, 77, 32'h0000_0ABC);
    swRd(2'd1, 77, r); check("R6 bias read", r, 32'h0000_0ABC);
    swWr(2'd1, 77, 32'h0001_0ABC);
    swRd(2'd1, 77, r); check("R7 parity flag", r, 32'h0000_8ABC);
    swWr(2'd1, 77, 32'h0000_0ABC);
    swRd(2'd1, 77, r); check("R7 flag cleared", r, 32'h0000_0ABC);

    // R10 software bitmap write, R5 single-bit update
    swWr(2'd2, 3, 32'hDEAD_BEEF);
    swRd(2'd2, 3, r); check("R10 word write", r, 32'hDEAD_BEEF);
    swWr(2'd2, 0, 32'hFFFF_FFFF);
    swWr(2'd0, 0, 32'd0);
    swWr(2'd1, 2, 32'd500);
    sendPix(0, 2, 0, 10);
    swRd(2'd2, 0, r); check("R5 only bit 2 cleared", r, 32'hFFFF_FFFB);

    // R8 stalled pixel is not taken
    swWr(2'd1, 12 * COLS + 1, 32'd0);
    swWr(2'd1, 12 * COLS + 2, 32'd0);
    @(negedge clk);
    swReq = 1; swWrite = 0; swSel = 2'd0; swAddr = 0;
    pixValid = 1; pixChan = 0; pixX = 1; pixY = 12; pixData = 12'd900;
    #1 check("R8 ready low", 32'(pixReady), 32'd0);
    @(negedge clk);
    swReq = 0; pixX = 2;
    #1 check("R8 ready back", 32'(pixReady), 32'd1);
    @(negedge clk);
    pixValid = 0;
    getBit(1, 12, b); check("R8 stalled pixel dropped", 32'(b), 32'd0);
    getBit(2, 12, b); check("R8 released pixel taken", 32'(b), 32'd1);

    // R8 captured sum survives a bias rewrite during stall
    swWr(2'd1, 9 * COLS + 8, 32'd10);
    @(negedge clk);
    pixValid = 1; pixChan = 0; pixX = 8; pixY = 9; pixData = 12'd20;
    @(negedge clk);
    pixValid = 0; swReq = 1; swWrite = 1; swSel = 2'd1; swAddr = 12'(9 * COLS + 8); swWdata = 32'd4000;
    @(negedge clk);
    swReq = 0; swWrite = 0;
    getBit(8, 9, b); check("R8 captured sum", 32'(b), 32'd1);
    swRd(2'd1, 9 * COLS + 8, r); check("R6 rewrite landed", r, 32'd4000);

    // R9 back-to-back pixels, row 5 columns 0..3 -> word 10 bits 0..3
    for (int x = 0; x < 4; x++) swWr(2'd1, 5 * COLS + x, 32'd100);
    for (int x = 0; x < 4; x++) begin
      @(negedge clk);
      pixValid = 1; pixChan = 0; pixX = 6'(x); pixY = 5;
      pixData = (x % 2 == 0) ? 12'd101 : 12'd100;
      #1 check("R9 ready each cycle", 32'(pixReady), 32'd1);
    end
    @(negedge clk);
    pixValid = 0;
    swRd(2'd2, 10, r); check("R9 burst word", r & 32'hF, 32'h5);

    done = 1;
    finishRun();
  end

endmodule